// File: doc/BRIEF.md
# Crossbar Slave-Port Grant Arbiter

This block decides which of eight bus masters owns one slave port of a multi-master crossbar. Each master raises a request line and receives a one-hot grant. Software sets the grant policy through two 32-bit registers. A level word holds a 3-bit priority code for every master. A policy word selects the arbitration mode (fixed priority or round robin) and what the port does when nobody asks for it: it can park on a named master, stay with the most recent owner, or release the grant. A lock bit in the policy word freezes both registers until the next reset.

A master keeps the port while it holds its request, until a transfer-done pulse ends its ownership. When the current owner drops its request, or when the port is parked or free, the block picks a new owner from the requesters sampled at a clock edge. The new grant appears after that edge. A parked master already holds the grant, so it can start a transfer with no arbitration cycle.

Top module: `xbar_port_arb`

## Requirements
- R1: After reset the grant is 0x01 (parked on master 0). The level word reads 0x7654_3210, because each master's code equals its index. The policy word reads 0.
- R2: `cfg_addr`=0 selects the level word, where master m's code sits in bits 4m+2:4m. `cfg_addr`=1 selects the policy word, with bit 8 = mode (1 = round robin), bits 5:4 = parking policy, bits 2:0 = park master and bit 31 = lock. All other bits read back as 0, whatever was written to them.
- R3: In fixed mode, among the eligible requesters, the master with the lowest level code wins. When codes are equal, the lower master index wins.
- R4: In round-robin mode, the search starts at the index after the last owner and wraps from 7 to 0. Level codes other than 7 have no effect on the choice.
- R5: An owner that holds its request without transfer-done keeps the grant, whatever other masters request.
- R6: `xfer_done` ends ownership. In that cycle the block arbitrates again, with the owner taking part like any other requester.
- R7: A master whose level code is 7 is never granted, either by arbitration or by parking.
- R8: Parking policy 0: with no eligible requester, the grant goes to the master named in the park field.
- R9: Parking policy 1: with no eligible requester, the grant stays with (or returns to) the last master that won arbitration.
- R10: Parking policy 2 or 3: with no eligible requester, the grant is 0.
- R11: A parked master that raises its request keeps the grant in the next cycle, even when a master with a better level requests at the same time.
- R12: Once the lock bit is written as 1, writes to either register are ignored.
- R13: At most one grant bit is high in any cycle.
- R14: A request sampled at an arbitration edge produces its grant one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 = level word, 1 = policy word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the selected register (combinational) |
| req | input | 8 | Per-master request |
| xfer_done | input | 1 | Ends the current owner's transfer |
| gnt | output | 8 | One-hot (or zero) per-master grant |

## Verification
The bench builds the block with its default parameters: eight masters with 3-bit level codes placed at a 4-bit stride. These are the values the register layout assumes, so every park target, every round-robin wrap from master 7 to master 0 and the invalid code 7 can all be reached. Random requests, done pulses and register rewrites drive a cycle model in the bench. Directed sequences cover the ties, parking, the parked-master fast start and the lock.

// File: rtl/xbar_arb_pkg.sv
package xbar_arb_pkg;
  localparam int NM        = 8;             // masters
  localparam int IW        = $clog2(NM);    // master index width
  localparam int LW        = 3;             // level code width
  localparam int STRIDE    = 4;             // level field spacing
  localparam int DW        = 32;            // register width
  localparam int MODE_BIT  = 8;
  localparam int PCTL_LO   = 4;
  localparam int LOCK_BIT  = 31;
  localparam logic [LW-1:0] LVL_BAD = '1;   // not a usable level

  typedef enum logic [1:0] {
    PARK_FIXED = 2'd0,
    PARK_LAST  = 2'd1,
    PARK_OFF   = 2'd2,
    PARK_OFF3  = 2'd3
  } park_pol_e;

  typedef struct packed {
    logic          lock;
    logic          rr;
    park_pol_e     pctl;
    logic [IW-1:0] park;
  } pol_t;

  function automatic logic [LW-1:0] lvl_of(logic [DW-1:0] prio, int m);
    return prio[m*STRIDE +: LW];
  endfunction

  function automatic logic [DW-1:0] field_mask();
    logic [DW-1:0] k = '0;
    for (int m = 0; m < NM; m++) k[m*STRIDE +: LW] = '1;
    return k;
  endfunction

  function automatic logic [DW-1:0] reset_levels();
    logic [DW-1:0] k = '0;
    for (int m = 0; m < NM; m++) k[m*STRIDE +: LW] = LW'(m);
    return k;
  endfunction

  function automatic logic [NM-1:0] usable(logic [DW-1:0] prio);
    logic [NM-1:0] u;
    for (int m = 0; m < NM; m++) u[m] = (lvl_of(prio, m) != LVL_BAD);
    return u;
  endfunction

  // lowest code wins, strict compare keeps the lower index on ties
  function automatic logic [IW-1:0] pick_fixed(logic [NM-1:0] elig, logic [DW-1:0] prio);
    logic [LW-1:0] best = LVL_BAD;
    logic [IW-1:0] idx  = '0;
    for (int m = 0; m < NM; m++)
      if (elig[m] && lvl_of(prio, m) < best) begin
        best = lvl_of(prio, m);
        idx  = IW'(m);
      end
    return idx;
  endfunction

  function automatic logic [IW-1:0] pick_rr(logic [NM-1:0] elig, logic [IW-1:0] last);
    logic [IW-1:0] idx = last;
    logic          hit = 1'b0;
    for (int k = 1; k <= NM; k++) begin
      logic [IW-1:0] c;
      c = IW'((int'(last) + k) % NM);
      if (!hit && elig[c]) begin
        idx = c;
        hit = 1'b1;
      end
    end
    return idx;
  endfunction

  function automatic logic [DW-1:0] pol_word(pol_t p);
    logic [DW-1:0] w = '0;
    w[LOCK_BIT]             = p.lock;
    w[MODE_BIT]             = p.rr;
    w[PCTL_LO +: 2]         = p.pctl;
    w[IW-1:0]               = p.park;
    return w;
  endfunction
endpackage

// File: rtl/xbar_arb_regs.sv
module xbar_arb_regs
  import xbar_arb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] prio_o,
  output pol_t          pol_o
);
  logic [DW-1:0] prio_q;
  pol_t          pol_q;
  logic          wr_ok;

  assign wr_ok = wr_en && !pol_q.lock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q <= reset_levels();
      pol_q  <= '{lock: 1'b0, rr: 1'b0, pctl: PARK_FIXED, park: '0};
    end else if (wr_ok) begin
      if (!addr) prio_q <= wdata & field_mask();
      else begin
        pol_q.lock <= wdata[LOCK_BIT];
        pol_q.rr   <= wdata[MODE_BIT];
        pol_q.pctl <= park_pol_e'(wdata[PCTL_LO +: 2]);
        pol_q.park <= wdata[IW-1:0];
      end
    end
  end

  assign rdata  = addr ? pol_word(pol_q) : prio_q;
  assign prio_o = prio_q;
  assign pol_o  = pol_q;
endmodule

// File: rtl/xbar_arb_pick.sv
module xbar_arb_pick
  import xbar_arb_pkg::*;
(
  input  logic [NM-1:0] req,
  input  logic [DW-1:0] prio,
  input  logic          rr,
  input  logic [IW-1:0] last,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [NM-1:0] elig;

  assign elig = req & usable(prio);
  assign any  = |elig;
  assign idx  = rr ? pick_rr(elig, last) : pick_fixed(elig, prio);
endmodule

// File: rtl/xbar_port_arb.sv
module xbar_port_arb
  import xbar_arb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic [NM-1:0] req,
  input  logic          xfer_done,
  output logic [NM-1:0] gnt
);
  logic [DW-1:0] prio_w;
  pol_t          pol_w;
  logic [DW-1:0] pol_word_w;
  logic          lock_w;
  logic [NM-1:0] gnt_q;
  logic [IW-1:0] last_q;
  logic          owner_busy;
  logic          arb_fire;
  logic          win_any;
  logic [IW-1:0] win_idx;
  logic [IW-1:0] park_idx;
  logic          park_on;

  xbar_arb_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_wr),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .rdata  (cfg_rdata),
    .prio_o (prio_w),
    .pol_o  (pol_w)
  );

  xbar_arb_pick u_pick (
    .req  (req),
    .prio (prio_w),
    .rr   (pol_w.rr),
    .last (last_q),
    .any  (win_any),
    .idx  (win_idx)
  );

  assign lock_w     = pol_w.lock;
  assign pol_word_w = pol_word(pol_w);
  assign owner_busy = (|(gnt_q & req)) && !xfer_done;
  assign arb_fire   = !owner_busy;
  assign park_idx   = (pol_w.pctl == PARK_FIXED) ? pol_w.park : last_q;
  assign park_on    = ((pol_w.pctl == PARK_FIXED) || (pol_w.pctl == PARK_LAST))
                      && usable(prio_w)[park_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q  <= NM'(1);
      last_q <= '0;
    end else if (arb_fire) begin
      if (win_any) begin
        gnt_q  <= NM'(1) << win_idx;
        last_q <= win_idx;
      end else begin
        gnt_q  <= park_on ? (NM'(1) << park_idx) : '0;
      end
    end
  end

  assign gnt = gnt_q;
endmodule

// File: rtl/xbar_port_arb_chk.sv
module xbar_port_arb_chk
  import xbar_arb_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [NM-1:0] req,
  input logic          xfer_done,
  input logic [NM-1:0] gnt,
  input logic [DW-1:0] prio,
  input logic [DW-1:0] pol_word,
  input logic          lock,
  input logic          arb_fire,
  input logic          win_any
);
  assert_onehot_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_no_preempt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(gnt & req)) && !xfer_done) |=> (gnt == $past(gnt)));

  assert_grant_next_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_fire && win_any) |=> (|(gnt & $past(req))));

  assert_lock_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> ($stable(prio) && $stable(pol_word)));

  for (genvar m = 0; m < NM; m++) begin : g_bad
    assert_no_bad_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gnt[m]) |-> ($past(prio[m*STRIDE +: LW]) != LVL_BAD));
  end
endmodule

bind xbar_port_arb xbar_port_arb_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req),
  .xfer_done (xfer_done),
  .gnt       (gnt),
  .prio      (prio_w),
  .pol_word  (pol_word_w),
  .lock      (lock_w),
  .arb_fire  (arb_fire),
  .win_any   (win_any)
);

// File: tb/xbar_port_arb_tb.sv
module xbar_port_arb_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NMS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [7:0]  req = '0;
  logic        xfer_done = 1'b0;
  logic [7:0]  gnt;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic [7:0]  m_gnt;
  int          m_last;
  logic [31:0] m_prio;
  logic        m_rr, m_lock;
  logic [1:0]  m_pctl;
  int          m_park;

  xbar_port_arb u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req(req),
    .xfer_done(xfer_done), .gnt(gnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic int lv(int m);
    return int'((m_prio >> (4*m)) & 32'h7);
  endfunction

  function automatic logic [7:0] okmask();
    logic [7:0] r;
    for (int m = 0; m < NMS; m++) r[m] = (lv(m) != 7);
    return r;
  endfunction

  function automatic int fixed_win(logic [7:0] e);
    for (int l = 0; l < 7; l++)
      for (int m = 0; m < NMS; m++)
        if (e[m] && lv(m) == l) return m;
    return -1;
  endfunction

  function automatic int rr_win(logic [7:0] e);
    for (int k = 1; k <= NMS; k++) begin
      int m;
      m = (m_last + k) % NMS;
      if (e[m]) return m;
    end
    return -1;
  endfunction

  function automatic logic [31:0] pol_exp();
    return {m_lock, 22'd0, m_rr, 2'd0, m_pctl, 1'b0, 3'(m_park)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_gnt = 8'h01; m_last = 0; m_prio = 32'h7654_3210;
    m_rr = 0; m_lock = 0; m_pctl = 0; m_park = 0;
  endtask

  task automatic model_step(logic [7:0] r, logic d, logic w, logic a, logic [31:0] wd);
    bit busy;
    busy = ((m_gnt & r) != 0) && !d;
    if (!busy) begin
      logic [7:0] e;
      int win;
      e = r & okmask();
      win = m_rr ? rr_win(e) : fixed_win(e);
      if (win >= 0) begin
        m_gnt = 8'(1 << win);
        m_last = win;
      end else if (m_pctl == 0) m_gnt = (lv(m_park) != 7) ? 8'(1 << m_park) : 8'h00;
      else if (m_pctl == 1) m_gnt = (lv(m_last) != 7) ? 8'(1 << m_last) : 8'h00;
      else m_gnt = 8'h00;
    end
    if (w && !m_lock) begin
      if (!a) m_prio = wd & 32'h7777_7777;
      else begin
        m_lock = wd[31]; m_rr = wd[8]; m_pctl = wd[5:4]; m_park = int'(wd[2:0]);
      end
    end
  endtask

  // drive at a falling edge, let one rising edge pass, compare at the next falling edge
  task automatic cyc(logic [7:0] r, logic d, logic w, logic a, logic [31:0] wd, string tag);
    req = r; xfer_done = d; cfg_wr = w; cfg_addr = a; cfg_wdata = wd;
    model_step(r, d, w, a, wd);
    @(negedge clk);
    chk(tag, {24'd0, gnt}, {24'd0, m_gnt});
    chk("R13", {31'd0, $countones(gnt) <= 1}, 32'd1);
  endtask

  task automatic rd(logic a, logic [31:0] exp, string tag);
    cfg_wr = 0; cfg_addr = a; req = '0; xfer_done = 0;
    #1;
    chk(tag, cfg_rdata, exp);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    chk("R1", {24'd0, gnt}, 32'h01);
    rd(0, 32'h7654_3210, "R1");
    rd(1, 32'h0, "R1");

    // latency: master 3 alone while port parked on 0
    cyc(8'h08, 0, 0, 0, 0, "R14");
    chk("R14", {24'd0, gnt}, 32'h08);
    // master 1 (better level) cannot preempt a busy owner
    cyc(8'h0A, 0, 0, 0, 0, "R5");
    cyc(8'h0A, 0, 0, 0, 0, "R5");
    chk("R5", {24'd0, gnt}, 32'h08);
    // done ends ownership, master 1 wins on level
    cyc(8'h0A, 1, 0, 0, 0, "R6");
    chk("R6", {24'd0, gnt}, 32'h02);
    // tie: masters 2 and 5 both level 1
    cyc(8'h00, 0, 1, 0, 32'h7613_5110, "R3");
    cyc(8'h24, 0, 0, 0, 0, "R3");
    chk("R3", {24'd0, gnt}, 32'h04);
    // level 7 never granted: master 7 alone, park on 0
    cyc(8'h80, 1, 0, 0, 0, "R7");
    chk("R7", {24'd0, gnt}, 32'h01);
    // park on master 4, then 4 requests together with better master 0
    cyc(8'h00, 0, 1, 1, 32'h0000_0004, "R8");
    cyc(8'h00, 0, 0, 0, 0, "R8");
    chk("R8", {24'd0, gnt}, 32'h10);
    cyc(8'h11, 0, 0, 0, 0, "R11");
    chk("R11", {24'd0, gnt}, 32'h10);
    // park on last owner
    cyc(8'h00, 0, 1, 1, 32'h0000_0010, "R9");
    cyc(8'h40, 1, 0, 0, 0, "R9");
    cyc(8'h00, 0, 0, 0, 0, "R9");
    cyc(8'h00, 0, 0, 0, 0, "R9");
    chk("R9", {24'd0, gnt}, 32'h40);
    // no parking
    cyc(8'h00, 0, 1, 1, 32'h0000_0020, "R10");
    cyc(8'h00, 0, 0, 0, 0, "R10");
    chk("R10", {24'd0, gnt}, 32'h00);
    cyc(8'h00, 0, 1, 1, 32'h0000_0030, "R10");
    cyc(8'h00, 0, 0, 0, 0, "R10");
    chk("R10", {24'd0, gnt}, 32'h00);
    // round robin, everyone requesting, done every cycle
    cyc(8'h00, 0, 1, 0, 32'h0123_4560, "R4");
    cyc(8'h00, 0, 1, 1, 32'h0000_0100, "R4");
    for (int i = 0; i < 10; i++) cyc(8'hFF, 1, 0, 0, 0, "R4");
    // register field layout
    cyc(8'h00, 0, 1, 0, 32'hFFFF_FFFF, "R2");
    rd(0, 32'h7777_7777, "R2");
    cyc(8'h00, 0, 1, 1, 32'h7FFF_FFFF, "R2");
    rd(1, 32'h0000_0137, "R2");
    cyc(8'h00, 0, 1, 0, 32'h0615_2430, "R2");
    rd(0, 32'h0615_2430, "R2");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [7:0]  r;
      logic        d, w, a;
      logic [31:0] wd;
      r = 8'($urandom) & 8'($urandom);
      d = ($urandom_range(0, 9) < 3);
      w = ($urandom_range(0, 39) == 0);
      a = 1'($urandom);
      wd = '0;
      if (w && !a)
        for (int m = 0; m < NMS; m++)
          wd[4*m +: 3] = ($urandom_range(0, 7) == 0) ? 3'd7 : 3'($urandom_range(0, 6));
      else if (w)
        wd = {23'd0, 1'($urandom), 2'd0, 2'($urandom), 1'b0, 3'($urandom)};
      cyc(r, d, w, a, wd, m_rr ? "R4" : "R3");
    end

    // lock
    cyc(8'h00, 0, 1, 1, 32'h8000_0000, "R12");
    rd(1, 32'h8000_0000, "R12");
    rd(0, pol_exp() == 32'h8000_0000 ? m_prio : 32'hDEAD_BEEF, "R12");
    cyc(8'h00, 0, 1, 0, 32'h0000_0000, "R12");
    rd(0, m_prio, "R12");
    cyc(8'h00, 0, 1, 1, 32'h0000_0100, "R12");
    rd(1, 32'h8000_0000, "R12");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule